// File: doc/BRIEF.md
# Bus Byte-Strobe and Lane Parity Unit

This block turns a processor's 64-bit access request into the active-low byte strobes and parity bits that an external memory bus needs. The bus may be configured as 64, 32, 16 or 8 bits wide. From the configured width, the access size, the low address bits and the access kind, the unit picks the byte lanes that carry the access. It then drives one strobe per lane. On the two narrow widths, two of the strobe pins carry the low address bits instead of acting as byte enables.

Parity is even, with one bit per byte lane. When parity is switched on, the unit computes it for write data. It also checks the parity that comes back with read data, but only on the lanes the preceding request actually enabled. A mismatch raises a one-cycle memory-exception pulse and sets a sticky flag. A trap handler reads the flag through a small register port and clears it by writing 1.

The bus outputs are registered and appear one cycle after the request. Bus cycle sequencing, chip selects, wait states and bursts belong to neighbouring logic.

Top module: `bus_lane_parity_unit`

## Requirements
- R1: `cfg_width` selects the bus width: 3 means 64 bits, 2 means 32, 1 means 16 and 0 means 8. `req_size` selects the access size: 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. Strobe k (`bus_be_n[k]`, k = 0..7) covers data bits 63-8k down to 56-8k. On a 64-bit bus, the byte at address offset a goes to strobe a, and this holds the same for either byte order. `bus_valid`, `bus_be_n`, `bus_wdata` and `bus_wpar` update one cycle after `req_valid`.
- R2: On a 32-bit bus, offset a (mod 4) goes to strobe 4+a, and strobes 0..3 stay high.
- R3: On a 16-bit bus, offset a (mod 2) goes to strobe 6+a. Strobe 4 outputs address bit 1 and strobe 5 outputs address bit 0. Strobes 0..3 stay high.
- R4: On an 8-bit bus, only strobe 7 is a byte enable. Strobes 4 and 5 output address bits 1 and 0. Strobes 0..3 and 6 stay high.
- R5: An access wider than the bus asserts every byte-enable strobe of that width. Address bits below the access size are ignored.
- R6: A read with `req_fill` set (a cacheable or DMA read) asserts every byte-enable strobe of the width. A write with `req_fill` set is strobed normally.
- R7: With parity enabled, a write drives `bus_wpar[k]` as the XOR of data lane k, which gives even parity. Data lane k is the lane of strobe k. `bus_wdata` carries the request data. A read drives `bus_wpar` to 0.
- R8: With parity enabled, a response whose parity differs on any lane enabled by the latest request raises `mexc_pulse` in the next cycle, for exactly one cycle. Lanes that were not enabled, including address-carrying strobes, are ignored.
- R9: A detected error sets the flag at register 1, bit 0. The flag stays set until register 1 is written with 1. Writing 0 has no effect.
- R10: Register 0, bit 0 is the parity enable. While it is 0, `bus_wpar` is 0, no response is checked and the flag never sets.
- R11: After reset, all strobes are high, `bus_valid`, `bus_wpar`, `mexc_pulse` and both registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | 2 | Bus width code |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fill | input | 1 | Cacheable or DMA read |
| req_size | input | 2 | Access size code |
| req_addr | input | 3 | Address low bits |
| req_wdata | input | 64 | Write data |
| bus_valid | output | 1 | Bus outputs updated this cycle |
| bus_be_n | output | 8 | Active-low strobes, index k = strobe k |
| bus_wdata | output | 64 | Registered write data |
| bus_wpar | output | 8 | Write parity per lane |
| rsp_valid | input | 1 | Read data present |
| rsp_rdata | input | 64 | Read data |
| rsp_rpar | input | 8 | Read parity per lane |
| mexc_pulse | output | 1 | Memory-exception pulse |
| reg_we | input | 1 | Register write |
| reg_addr | input | 1 | 0 = parity enable, 1 = error flag |
| reg_wdata | input | 1 | Register write bit |
| reg_rdata | output | 8 | Register read value, bit 0 significant |

## Verification
A wrong lane base or offset in the strobe mapper shows up one cycle after the request as a misplaced or missing low strobe. Sweeping every combination of width, size, offset, direction and fill exposes it on the first affected combination. A stale lane mask or a stuck enable shows on the first response after the faulty request, as a missing or extra `mexc_pulse` one cycle later. A flag that clears wrongly, or does not stick, becomes visible the next time register 1 is read.

// File: rtl/blp_pkg.sv
package blp_pkg;
  typedef enum logic [1:0] {
    BW_8  = 2'd0,
    BW_16 = 2'd1,
    BW_32 = 2'd2,
    BW_64 = 2'd3
  } bus_width_e;

  typedef enum logic [1:0] {
    SZ_1 = 2'd0,
    SZ_2 = 2'd1,
    SZ_4 = 2'd2,
    SZ_8 = 2'd3
  } acc_size_e;

  localparam logic REG_CTRL = 1'b0;
  localparam logic REG_FLAG = 1'b1;
endpackage

// File: rtl/blp_strobe_map.sv
module blp_strobe_map
  import blp_pkg::*;
#(
  parameter int LANES = 8,
  localparam int AW = $clog2(LANES)
) (
  input  bus_width_e        width,
  input  acc_size_e         size,
  input  logic [AW-1:0]     addr,
  input  logic              fill,
  input  logic              write,
  output logic [LANES-1:0]  lane_en,
  output logic [LANES-1:0]  strobe_n
);
  logic [AW:0]   bus_bytes;
  logic [AW:0]   acc_bytes;
  logic [AW:0]   eff_bytes;
  logic [AW:0]   base;
  logic [AW:0]   lo;
  logic [AW:0]   hi;
  logic [AW-1:0] bus_mask;
  logic [AW-1:0] size_mask;
  logic [AW-1:0] offset;
  logic          all_lanes;
  logic          narrow;

  always_comb begin
    bus_bytes = (AW+1)'(1) << width;
    acc_bytes = (AW+1)'(1) << size;
    eff_bytes = (acc_bytes > bus_bytes) ? bus_bytes : acc_bytes;
    bus_mask  = AW'(bus_bytes - (AW+1)'(1));
    size_mask = AW'(eff_bytes - (AW+1)'(1));
    offset    = addr & bus_mask & ~size_mask;
    base      = (AW+1)'(LANES) - bus_bytes;
    lo        = base + (AW+1)'(offset);
    hi        = lo + eff_bytes;
    all_lanes = fill && !write;
    narrow    = (width == BW_8) || (width == BW_16);
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [AW:0] IDX = (AW+1)'(i);
    assign lane_en[i] = all_lanes ? (IDX >= base) : ((IDX >= lo) && (IDX < hi));
    if (i == LANES - 4) begin : g_adr_hi
      assign strobe_n[i] = narrow ? addr[1] : !lane_en[i];
    end else if (i == LANES - 3) begin : g_adr_lo
      assign strobe_n[i] = narrow ? addr[0] : !lane_en[i];
    end else begin : g_plain
      assign strobe_n[i] = !lane_en[i];
    end
  end
endmodule

// File: rtl/blp_lane_parity.sv
module blp_lane_parity #(
  parameter int LANES = 8,
  localparam int DW = 8 * LANES
) (
  input  logic [DW-1:0]    data,
  output logic [LANES-1:0] par
);
  for (genvar i = 0; i < LANES; i++) begin : g_par
    assign par[i] = ^data[8*(LANES-1-i) +: 8];
  end
endmodule

// File: rtl/blp_err_reg.sv
module blp_err_reg
  import blp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic reg_we,
  input  logic reg_addr,
  input  logic reg_wdata,
  input  logic chk_fire,
  output logic par_en,
  output logic err_flag,
  output logic mexc_pulse
);
  logic par_en_q, par_en_d;
  logic flag_q, flag_d;
  logic mexc_q, mexc_d;

  always_comb begin
    par_en_d = par_en_q;
    flag_d   = flag_q;
    if (reg_we && reg_addr == REG_CTRL) par_en_d = reg_wdata;
    if (reg_we && reg_addr == REG_FLAG && reg_wdata) flag_d = 1'b0;
    if (chk_fire) flag_d = 1'b1;
    mexc_d = chk_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_en_q <= 1'b0;
      flag_q   <= 1'b0;
      mexc_q   <= 1'b0;
    end else begin
      par_en_q <= par_en_d;
      flag_q   <= flag_d;
      mexc_q   <= mexc_d;
    end
  end

  assign par_en     = par_en_q;
  assign err_flag   = flag_q;
  assign mexc_pulse = mexc_q;
endmodule

// File: rtl/bus_lane_parity_unit.sv
module bus_lane_parity_unit
  import blp_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int LANES = DATA_W / 8,
  localparam int AW = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_width,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_fill,
  input  logic [1:0]        req_size,
  input  logic [AW-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              bus_valid,
  output logic [LANES-1:0]  bus_be_n,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [LANES-1:0]  bus_wpar,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_rdata,
  input  logic [LANES-1:0]  rsp_rpar,
  output logic              mexc_pulse,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic              reg_wdata,
  output logic [7:0]        reg_rdata
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [LANES-1:0]  lane_en, strobe_n;
  logic [LANES-1:0]  wr_par, rd_par;
  logic              par_en, err_flag, chk_fire;

  logic              valid_q, valid_d;
  logic [LANES-1:0]  be_n_q, be_n_d;
  logic [LANES-1:0]  act_q, act_d;
  logic [LANES-1:0]  wpar_q, wpar_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  blp_strobe_map #(.LANES(LANES)) u_map (
    .width    (bus_width_e'(cfg_width)),
    .size     (acc_size_e'(req_size)),
    .addr     (req_addr),
    .fill     (req_fill),
    .write    (req_write),
    .lane_en  (lane_en),
    .strobe_n (strobe_n)
  );

  blp_lane_parity #(.LANES(LANES)) u_wpar (.data(req_wdata), .par(wr_par));
  blp_lane_parity #(.LANES(LANES)) u_rpar (.data(rsp_rdata), .par(rd_par));

  always_comb begin
    valid_d = req_valid;
    be_n_d  = be_n_q;
    act_d   = act_q;
    wpar_d  = wpar_q;
    wdata_d = wdata_q;
    if (req_valid) begin
      be_n_d  = strobe_n;
      act_d   = lane_en;
      wdata_d = req_wdata;
      wpar_d  = (par_en && req_write) ? wr_par : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      be_n_q  <= '1;
      act_q   <= '0;
      wpar_q  <= '0;
      wdata_q <= '0;
    end else begin
      valid_q <= valid_d;
      be_n_q  <= be_n_d;
      act_q   <= act_d;
      wpar_q  <= wpar_d;
      wdata_q <= wdata_d;
    end
  end

  assign chk_fire = rsp_valid && par_en && |(act_q & (rsp_rpar ^ rd_par));

  blp_err_reg u_err (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .chk_fire   (chk_fire),
    .par_en     (par_en),
    .err_flag   (err_flag),
    .mexc_pulse (mexc_pulse)
  );

  assign bus_valid = valid_q;
  assign bus_be_n  = be_n_q;
  assign bus_wpar  = wpar_q;
  assign bus_wdata = wdata_q;
  assign reg_rdata = {7'b0, (reg_addr == REG_FLAG) ? err_flag : par_en};
endmodule

// File: rtl/blp_checker.sv
module blp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_write,
  input logic [1:0] cfg_width,
  input logic [2:0] req_addr,
  input logic       bus_valid,
  input logic [7:0] bus_be_n,
  input logic [7:0] bus_wpar,
  input logic       rsp_valid,
  input logic       mexc_pulse,
  input logic       reg_we,
  input logic       reg_addr,
  input logic       reg_wdata0,
  input logic       reg_rdata0,
  input logic       err_flag,
  input logic       par_en
);
  AST_W32_UPPER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && $past(cfg_width) == 2'd2 |-> bus_be_n[3:0] == 4'hF); // R2

  AST_W16_ADDR_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && $past(cfg_width) == 2'd1 |->
      bus_be_n[4] == $past(req_addr[1]) && bus_be_n[5] == $past(req_addr[0]) && bus_be_n[3:0] == 4'hF); // R3

  AST_W8_SINGLE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && $past(cfg_width) == 2'd0 |-> bus_be_n[6] && bus_be_n[3:0] == 4'hF); // R4

  AST_READ_NO_WPAR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !$past(req_write) |-> bus_wpar == 8'h00); // R7

  AST_MEXC_FROM_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    mexc_pulse |-> $past(rsp_valid)); // R8

  AST_FLAG_ON_MEXC: assert property (@(posedge clk) disable iff (!rst_n)
    mexc_pulse && reg_addr |-> reg_rdata0); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_flag) |-> $past(reg_we && reg_addr && reg_wdata0)); // R9

  AST_OFF_NO_WPAR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !$past(par_en) |-> bus_wpar == 8'h00); // R10

  AST_OFF_NO_MEXC: assert property (@(posedge clk) disable iff (!rst_n)
    mexc_pulse |-> $past(par_en)); // R10
endmodule

bind bus_lane_parity_unit blp_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_write  (req_write),
  .cfg_width  (cfg_width),
  .req_addr   (req_addr),
  .bus_valid  (bus_valid),
  .bus_be_n   (bus_be_n),
  .bus_wpar   (bus_wpar),
  .rsp_valid  (rsp_valid),
  .mexc_pulse (mexc_pulse),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .reg_wdata0 (reg_wdata),
  .reg_rdata0 (reg_rdata[0]),
  .err_flag   (err_flag),
  .par_en     (par_en)
);

// File: tb/tb_bus_lane_parity_unit.sv
`timescale 1ns/100ps
module tb_bus_lane_parity_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cfg_width;
  logic        req_valid, req_write, req_fill;
  logic [1:0]  req_size;
  logic [2:0]  req_addr;
  logic [63:0] req_wdata;
  logic        bus_valid;
  logic [7:0]  bus_be_n, bus_wpar;
  logic [63:0] bus_wdata;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic [7:0]  rsp_rpar;
  logic        mexc_pulse;
  logic        reg_we, reg_addr, reg_wdata;
  logic [7:0]  reg_rdata;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  bus_lane_parity_unit dut (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width),
    .req_valid(req_valid), .req_write(req_write), .req_fill(req_fill),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .bus_valid(bus_valid), .bus_be_n(bus_be_n), .bus_wdata(bus_wdata),
    .bus_wpar(bus_wpar), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_rpar(rsp_rpar), .mexc_pulse(mexc_pulse), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic logic [7:0] exp_be(int w, int s, int a, bit f, bit wr);
    int bw = 1 << w;
    int n = 1 << s;
    logic [7:0] r = 8'hFF;
    if (n > bw) n = bw;
    if (f && !wr) begin
      for (int k = 8 - bw; k < 8; k++) r[k] = 1'b0;
    end else begin
      int st = ((a % bw) / n) * n;
      for (int j = 0; j < n; j++) r[8 - bw + st + j] = 1'b0;
    end
    if (w < 2) begin
      r[4] = ((a >> 1) & 1) != 0;
      r[5] = (a & 1) != 0;
    end
    return r;
  endfunction

  function automatic logic [7:0] exp_par(logic [63:0] d);
    logic [7:0] p;
    for (int k = 0; k < 8; k++) p[k] = ($countones(d[63-8*k -: 8]) % 2) == 1;
    return p;
  endfunction

  task automatic do_req(int w, int s, int a, bit wr, bit f, logic [63:0] d);
    @(negedge clk);
    cfg_width = 2'(w); req_size = 2'(s); req_addr = 3'(a);
    req_write = wr; req_fill = f; req_wdata = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic reg_write(bit a, bit v);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(bit a, output logic [7:0] v);
    reg_addr = a;
    #0.5;
    v = reg_rdata;
  endtask

  task automatic do_rsp(logic [63:0] d, logic [7:0] p, bit expect_mexc, string req);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_rdata = d; rsp_rpar = p;
    @(negedge clk);
    rsp_valid = 1'b0;
    chk(mexc_pulse == expect_mexc, req, 64'(mexc_pulse), 64'(expect_mexc));
    @(negedge clk);
    chk(mexc_pulse == 1'b0, "R8 pulse one cycle", 64'(mexc_pulse), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] rv;
    logic [63:0] d;
    logic [7:0] p;
    logic [63:0] pats [5];
    string tag;
    rst_n = 1'b0;
    cfg_width = 2'd3; req_valid = 0; req_write = 0; req_fill = 0;
    req_size = 0; req_addr = 0; req_wdata = '0;
    rsp_valid = 0; rsp_rdata = '0; rsp_rpar = '0;
    reg_we = 0; reg_addr = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk(bus_be_n == 8'hFF, "R11 strobes", 64'(bus_be_n), 64'hFF);
    chk(bus_valid == 1'b0, "R11 valid", 64'(bus_valid), 64'd0);
    chk(bus_wpar == 8'h00, "R11 wpar", 64'(bus_wpar), 64'd0);
    chk(mexc_pulse == 1'b0, "R11 mexc", 64'(mexc_pulse), 64'd0);
    reg_read(1'b0, rv); chk(rv == 8'h00, "R11 enable reg", 64'(rv), 64'd0);
    reg_read(1'b1, rv); chk(rv == 8'h00, "R11 flag reg", 64'(rv), 64'd0);

    // R1..R6 full sweep of strobe mapping
    for (int w = 0; w < 4; w++)
      for (int s = 0; s < 4; s++)
        for (int a = 0; a < 8; a++)
          for (int wr = 0; wr < 2; wr++)
            for (int f = 0; f < 2; f++) begin
              do_req(w, s, a, wr[0], f[0], 64'h0);
              if (f == 1 && wr == 0) tag = "R6";
              else if (s > w) tag = "R5";
              else if (w == 3) tag = "R1";
              else if (w == 2) tag = "R2";
              else if (w == 1) tag = "R3";
              else tag = "R4";
              chk(bus_be_n == exp_be(w, s, a, f[0], wr[0]), tag,
                  64'(bus_be_n), 64'(exp_be(w, s, a, f[0], wr[0])));
              chk(bus_valid == 1'b1, "R1 valid", 64'(bus_valid), 64'd1);
            end

    // R7 write parity
    pats[0] = 64'h0; pats[1] = '1; pats[2] = 64'h0123_4567_89AB_CDEF;
    pats[3] = 64'h8000_0000_0000_0001; pats[4] = 64'h7F3C_0155_AA81_FE10;
    reg_write(1'b0, 1'b1);
    reg_read(1'b0, rv); chk(rv == 8'h01, "R10 enable readback", 64'(rv), 64'd1);
    for (int i = 0; i < 5; i++) begin
      do_req(3, 3, 0, 1'b1, 1'b0, pats[i]);
      chk(bus_wpar == exp_par(pats[i]), "R7 wpar", 64'(bus_wpar), 64'(exp_par(pats[i])));
      chk(bus_wdata == pats[i], "R7 wdata", bus_wdata, pats[i]);
    end
    do_req(3, 3, 0, 1'b0, 1'b0, pats[2]);
    chk(bus_wpar == 8'h00, "R7 read wpar", 64'(bus_wpar), 64'd0);

    // R8 / R9 read checking
    d = 64'hA5C3_0F1E_7788_9901;
    p = exp_par(d);
    do_rsp(d, p, 1'b0, "R8 clean");
    for (int k = 0; k < 8; k++) begin
      do_rsp(d, p ^ 8'(1 << k), 1'b1, "R8 lane error");
      reg_read(1'b1, rv); chk(rv == 8'h01, "R9 flag set", 64'(rv), 64'd1);
      reg_write(1'b1, 1'b0);
      reg_read(1'b1, rv); chk(rv == 8'h01, "R9 write 0 keeps", 64'(rv), 64'd1);
      reg_write(1'b1, 1'b1);
      reg_read(1'b1, rv); chk(rv == 8'h00, "R9 write 1 clears", 64'(rv), 64'd0);
    end
    do_req(3, 0, 2, 1'b0, 1'b0, 64'h0);
    do_rsp(d, p ^ 8'h20, 1'b0, "R8 inactive lane ignored");
    reg_read(1'b1, rv); chk(rv == 8'h00, "R8 inactive no flag", 64'(rv), 64'd0);
    do_rsp(d, p ^ 8'h04, 1'b1, "R8 active lane");
    reg_write(1'b1, 1'b1);
    do_req(0, 3, 3, 1'b0, 1'b1, 64'h0);
    do_rsp(d, p ^ 8'h30, 1'b0, "R8 address strobes ignored");
    do_rsp(d, p ^ 8'h80, 1'b1, "R8 narrow lane");
    reg_write(1'b1, 1'b1);

    // R10 parity disabled
    reg_write(1'b0, 1'b0);
    reg_read(1'b0, rv); chk(rv == 8'h00, "R10 enable off", 64'(rv), 64'd0);
    do_req(3, 3, 0, 1'b0, 1'b0, 64'h0);
    do_rsp(d, ~p, 1'b0, "R10 no check");
    reg_read(1'b1, rv); chk(rv == 8'h00, "R10 flag stays", 64'(rv), 64'd0);
    do_req(3, 3, 0, 1'b1, 1'b0, pats[4]);
    chk(bus_wpar == 8'h00, "R10 wpar off", 64'(bus_wpar), 64'd0);

    finish_run();
  end
endmodule